// File: doc/BRIEF.md
# Bus Slave Termination Responder

This block is the slave side of a shared, three-stateable system bus. It watches for an address phase and checks the address against a fixed window. A transfer aimed at that window is then answered with a data phase. Every shared line the block can drive comes out as a value together with an enable. When the enable is low, the line is taken to be pulled to its inactive level. The block turns its enables on only in the cycle after an address phase that selected it. It turns them off in the cycle after it terminates the transfer.

Each data beat waits for a configurable number of wait states, from 0 to 7 cycles. The beat then ends with one of two terminations. A normal acknowledge marks a good beat. An error acknowledge marks an access to a word offset in the window that has no register behind it, or a misaligned address. Bursts run beat by beat while the master signals that another beat follows. A master that requests a burst from the block while it is configured as not burst-capable is told so with burst inhibit and gets a single beat. Behind the window sits a small register array that gives the transfers something to read and write.

The bus has no separate back-pressure channel. The acknowledge itself paces the transfer. The master holds its write data and its "beat follows" indication until it sees a termination. It must not start a new address phase while a data phase is open. A start in that window is ignored.

Top module: `tsr_top`

## Requirements
- R1: Once reset is released, the termination enable and the read-data enable are low, and every termination value and the read data are zero.
- R2: The enables rise only in the cycle after an address phase (`start_i` high) whose address lies in the window. The window is the addresses whose bits above bit WB-1 equal those of BASE, with WB = log2(WIN_WORDS)+2. While the address phase itself is on the bus, nothing is driven. A start outside the window is never answered.
- R3: Let W be the value of `wait_cfg_i`. Each beat holds the termination enable high with both acknowledge and error low for exactly W cycles. The beat's termination then appears in cycle W+1.
- R4: A good write stores `wdata_i` into the addressed register at the acknowledge edge. A good read presents that register on `rdata_o`, with `rdata_oe_o` high, in its acknowledge cycle. Registers reset to zero.
- R5: With `burst_cap_i` high, a burst (`burst_i`) acknowledges every beat. The word offset advances by one after each beat. Another beat follows whenever `more_i` is high at an acknowledge edge.
- R6: With `burst_cap_i` low, a burst request drives `binh_o` high for the whole data phase. Exactly one beat is terminated, whatever the state of `more_i`.
- R7: The word offset is addr[WB-1:2]. Offsets 0 to NREG-1 are implemented. An access to a higher offset, or to an address with addr[1:0] not zero, is answered by `err_o` instead of `ack_o`. It writes nothing and ends the transfer. `ack_o` and `err_o` are never high together.
- R8: A burst that advances onto an unimplemented offset acknowledges its earlier beats normally. It gets `err_o` on the first unimplemented beat and stops there.
- R9: In the cycle after the final acknowledge or error, every enable is low. Whenever an enable is low, the values it governs are zero, so a pulled-up line reads as inactive.
- R10: An address phase that arrives while a data phase is open is ignored. The open transfer completes unchanged, and no second transfer follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| wait_cfg_i | input | CW | Wait states per beat |
| burst_cap_i | input | 1 | High when the slave accepts bursts |
| start_i | input | 1 | Address phase strobe |
| addr_i | input | AW | Byte address of the transfer |
| wr_i | input | 1 | 1 = write, 0 = read |
| burst_i | input | 1 | Master requests a burst |
| more_i | input | 1 | Another data beat follows the current one |
| wdata_i | input | DW | Write data, valid for the current beat |
| rdata_o | output | DW | Read data value |
| rdata_oe_o | output | 1 | Read data enable |
| term_oe_o | output | 1 | Enable for the termination lines |
| ack_o | output | 1 | Transfer acknowledge value |
| err_o | output | 1 | Transfer error acknowledge value |
| binh_o | output | 1 | Burst inhibit value |

## Verification
Most internal faults surface at the ports within one beat. A miscounted wait register moves the acknowledge away from cycle W+1 of the beat. A wrong busy flag shows up as enables that rise during the address phase or stay high after the final termination. A wrong offset register shows up as wrong read data, or as an error on the wrong beat of a burst. Faults in the register array itself stay hidden until a later read of the same word. For that reason, every write is followed by reads of the words it should and should not have touched.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

  // attributes of the open transfer, captured at the address phase
  typedef struct packed {
    logic wr;       // write transfer
    logic inhibit;  // burst requested but refused
    logic burst;    // burst accepted
    logic misal;    // low address bits not zero
  } xfer_attr_t;

endpackage

// File: rtl/tsr_decode.sv
module tsr_decode #(
  parameter int              AW   = 16,
  parameter int              WB   = 6,
  parameter logic [AW-1:0]   BASE = '0
) (
  input  logic [AW-1:0] addr_i,
  output logic          hit_o,
  output logic          misal_o,
  output logic [WB-3:0] word_o
);

  assign hit_o   = (addr_i[AW-1:WB] == BASE[AW-1:WB]);
  assign misal_o = (addr_i[1:0] != 2'b00);
  assign word_o  = addr_i[WB-1:2];

endmodule

// File: rtl/tsr_wait.sv
module tsr_wait #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/tsr_regs.sv
module tsr_regs #(
  parameter int DW   = 32,
  parameter int NREG = 8,
  parameter int IW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem_q [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      for (int i = 0; i < NREG; i++)
        if (idx_i == IW'(i)) mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];

endmodule

// File: rtl/tsr_top.sv
module tsr_top #(
  parameter int            AW        = 16,
  parameter int            DW        = 32,
  parameter logic [15:0]   BASE      = 16'h4000,
  parameter int            WIN_WORDS = 16,
  parameter int            NREG      = 8,
  parameter int            CW        = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] wait_cfg_i,
  input  logic          burst_cap_i,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          burst_i,
  input  logic          more_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rdata_oe_o,
  output logic          term_oe_o,
  output logic          ack_o,
  output logic          err_o,
  output logic          binh_o
);
  import tsr_pkg::*;

  localparam int WB = $clog2(WIN_WORDS) + 2;
  localparam int OW = WB - 2;
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [OW-1:0] NREG_W = OW'(NREG);

  logic          hit, misal;
  logic [OW-1:0] word;
  logic          cnt_zero;
  logic [DW-1:0] rd_word;

  logic          busy_q;
  xfer_attr_t    attr_q;
  logic [OW-1:0] cur_word_q;

  logic accept, beat_end, fault, ack_now, err_now, cont, we;

  tsr_decode #(.AW(AW), .WB(WB), .BASE(AW'(BASE))) u_dec (
    .addr_i (addr_i),
    .hit_o  (hit),
    .misal_o(misal),
    .word_o (word)
  );

  assign accept   = start_i && !busy_q && hit;
  assign beat_end = busy_q && cnt_zero;
  assign fault    = (cur_word_q >= NREG_W) || attr_q.misal;
  assign ack_now  = beat_end && !fault;
  assign err_now  = beat_end && fault;
  assign cont     = ack_now && attr_q.burst && more_i;
  assign we       = ack_now && attr_q.wr;

  tsr_wait #(.CW(CW)) u_wait (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(accept || cont),
    .val_i (wait_cfg_i),
    .zero_o(cnt_zero)
  );

  tsr_regs #(.DW(DW), .NREG(NREG), .IW(IW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (we),
    .idx_i  (cur_word_q[IW-1:0]),
    .wdata_i(wdata_i),
    .rdata_o(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      attr_q     <= '0;
      cur_word_q <= '0;
    end else if (accept) begin
      busy_q         <= 1'b1;
      attr_q.wr      <= wr_i;
      attr_q.inhibit <= burst_i && !burst_cap_i;
      attr_q.burst   <= burst_i && burst_cap_i;
      attr_q.misal   <= misal;
      cur_word_q     <= word;
    end else if (beat_end) begin
      if (cont) cur_word_q <= cur_word_q + 1'b1;
      else      busy_q     <= 1'b0;
    end
  end

  assign term_oe_o  = busy_q;
  assign ack_o      = ack_now;
  assign err_o      = err_now;
  assign binh_o     = busy_q && attr_q.inhibit;
  assign rdata_oe_o = busy_q && !attr_q.wr;
  assign rdata_o    = (rdata_oe_o && !fault) ? rd_word : '0;

endmodule

// File: rtl/tsr_checker.sv
module tsr_checker #(
  parameter int DW = 32,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [CW-1:0] wait_cfg_i,
  input logic          busy_i,
  input logic          term_oe_o,
  input logic          ack_o,
  input logic          err_o,
  input logic          binh_o,
  input logic          rdata_oe_o,
  input logic [DW-1:0] rdata_o
);

  a_r2_drive_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(term_oe_o) |-> $past(start_i));

  a_r7_one_termination: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_o && err_o));

  a_r8_error_releases: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !term_oe_o && !rdata_oe_o);

  a_r6_inhibit_one_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && binh_o) |=> !term_oe_o);

  a_r9_quiet_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !term_oe_o |-> !ack_o && !err_o && !binh_o);

  a_r9_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe_o |-> rdata_o == '0);

  a_r3_wait_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && wait_cfg_i != '0) |=> !ack_o);

  a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && start_i && !ack_o && !err_o) |=> busy_i);

endmodule

bind tsr_top tsr_checker #(.DW(DW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .wait_cfg_i(wait_cfg_i),
  .busy_i    (busy_q),
  .term_oe_o (term_oe_o),
  .ack_o     (ack_o),
  .err_o     (err_o),
  .binh_o    (binh_o),
  .rdata_oe_o(rdata_oe_o),
  .rdata_o   (rdata_o)
);

// File: tb/tb_tsr_top.sv
module tb_tsr_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  wait_cfg_i = '0;
  logic        burst_cap_i = 1'b1;
  logic        start_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic        wr_i = 1'b0;
  logic        burst_i = 1'b0;
  logic        more_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rdata_oe_o, term_oe_o, ack_o, err_o, binh_o;

  int checks = 0;
  int errors = 0;
  int seed = 1;
  logic [31:0] model [16];

  always #5 clk = ~clk;

  tsr_top dut (
    .clk(clk), .rst_n(rst_n), .wait_cfg_i(wait_cfg_i), .burst_cap_i(burst_cap_i),
    .start_i(start_i), .addr_i(addr_i), .wr_i(wr_i), .burst_i(burst_i),
    .more_i(more_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rdata_oe_o(rdata_oe_o),
    .term_oe_o(term_oe_o), .ack_o(ack_o), .err_o(err_o), .binh_o(binh_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] lines();
    return {term_oe_o, rdata_oe_o, ack_o, err_o, binh_o};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one transfer of nb beats; errors expected for offset >= 8 or misaligned
  task automatic xfer(input logic [15:0] a, input bit wr, input bit bst, input int nb,
                      input int w, input bit cap, input string req);
    bit inh;
    inh = bst && !cap;
    @(negedge clk);
    wait_cfg_i = 3'(w); burst_cap_i = cap; addr_i = a; wr_i = wr;
    burst_i = bst; more_i = (nb > 1); start_i = 1'b1;
    chk(lines() == 5'b0, "R2 no drive in address phase", 32'(lines()), 0);
    step();
    start_i = 1'b0;
    for (int b = 0; b < nb; b++) begin
      int  word;
      bit  exp_err;
      word = (int'(a[5:2]) + b) % 16;
      exp_err = (word >= 8) || (a[1:0] != 2'b00);
      wdata_i = 32'hA500_0000 ^ (32'(word) << 8) ^ 32'(seed);
      seed++;
      more_i = (b + 1 < nb);
      for (int c = 0; c < w; c++) begin
        chk(term_oe_o && !ack_o && !err_o, "R3 wait cycle", 32'(lines()), 32'h10);
        step();
      end
      chk(ack_o == !exp_err && err_o == exp_err, req, {30'b0, ack_o, err_o},
          {30'b0, !exp_err, exp_err});
      chk(binh_o == inh, "R6 burst inhibit", 32'(binh_o), 32'(inh));
      if (!exp_err && !wr)
        chk(rdata_oe_o && rdata_o == model[word], "R4 read data", rdata_o, model[word]);
      if (!exp_err && wr) model[word] = wdata_i;
      step();
      if (exp_err || inh) break;
    end
    more_i = 1'b0;
    chk(lines() == 5'b0, "R9 release after termination", 32'(lines()), 0);
    chk(rdata_o == '0, "R9 data quiet", rdata_o, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(lines() == 5'b0 && rdata_o == '0, "R1 reset state", 32'(lines()), 0);
  endtask

  task automatic t_miss();
    @(negedge clk);
    addr_i = 16'h5004; wr_i = 1'b0; burst_i = 1'b0; start_i = 1'b1;
    step();
    start_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(lines() == 5'b0, "R2 address miss ignored", 32'(lines()), 0);
      step();
    end
  endtask

  task automatic t_start_while_busy();
    @(negedge clk);
    wait_cfg_i = 3'd7; burst_cap_i = 1'b1; addr_i = 16'h4004; wr_i = 1'b0;
    burst_i = 1'b0; more_i = 1'b0; start_i = 1'b1;
    step();
    start_i = 1'b0;
    for (int c = 0; c < 7; c++) begin
      if (c == 2) begin
        start_i = 1'b1; addr_i = 16'h4008; wr_i = 1'b1; wdata_i = 32'hDEAD_BEEF;
      end else begin
        start_i = 1'b0; addr_i = 16'h4004; wr_i = 1'b0;
      end
      chk(!ack_o && !err_o, "R10 no early termination", 32'(lines()), 32'h18);
      step();
    end
    chk(ack_o && rdata_o == model[1], "R10 open transfer intact", rdata_o, model[1]);
    step();
    for (int i = 0; i < 3; i++) begin
      chk(lines() == 5'b0, "R10 no second transfer", 32'(lines()), 0);
      step();
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    xfer(16'h4000, 1'b1, 1'b0, 1, 0, 1'b1, "R4 write word 0");
    xfer(16'h400C, 1'b1, 1'b0, 1, 3, 1'b1, "R4 write word 3");
    xfer(16'h4000, 1'b0, 1'b0, 1, 0, 1'b1, "R3 zero wait read");
    xfer(16'h400C, 1'b0, 1'b0, 1, 7, 1'b1, "R3 seven wait read");
    xfer(16'h4008, 1'b0, 1'b0, 1, 2, 1'b1, "R4 untouched word");
    t_miss();
    xfer(16'h4010, 1'b1, 1'b1, 4, 1, 1'b1, "R5 burst write");
    xfer(16'h4010, 1'b0, 1'b1, 4, 0, 1'b1, "R5 burst read");
    xfer(16'h400C, 1'b0, 1'b1, 3, 2, 1'b1, "R5 burst read waits");
    xfer(16'h4008, 1'b0, 1'b1, 4, 1, 1'b0, "R6 refused burst");
    xfer(16'h4024, 1'b0, 1'b0, 1, 1, 1'b1, "R7 unimplemented offset");
    xfer(16'h4002, 1'b1, 1'b0, 1, 0, 1'b1, "R7 misaligned write");
    xfer(16'h4000, 1'b0, 1'b0, 1, 0, 1'b1, "R7 misaligned wrote nothing");
    xfer(16'h403C, 1'b1, 1'b0, 1, 0, 1'b1, "R7 top offset write");
    xfer(16'h4018, 1'b0, 1'b1, 4, 1, 1'b1, "R8 burst runs off implemented words");
    t_start_while_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule